// File: doc/BRIEF.md
# IDE PIO Strobe Timing Generator

This block times one programmed-I/O transfer on an IDE-style bus for any of four attached drives. It keeps a small set of timing registers, loaded and read back through a plain register port: each set holds a two-bit address-setup code and a timing byte with an active count and a recovery count. Drives 0 and 1 each have a set of their own. Drives 2 and 3 on the second channel share a single set.

When a start request arrives while the block is idle, it latches the counts of the selected drive's set and the transfer direction. It raises address-valid for the setup clocks, then holds the read or write strobe low for the active clocks, and then waits out the recovery clocks. A one-cycle done pulse closes the transfer. A chip-revision input stretches recovery by one clock on later revisions. The bus data path is not part of this block.

Top module: `ide_pio_strobe_gen`

## Requirements
- R1: After reset every register set holds setup code 00 and timing byte 0x00, so all sets give 4 setup, 16 active and 16 recovery clocks. After reset the outputs are idle: addr_valid 0, both strobes 1, busy 0, done 0.
- R2: The setup code sits in bits 7:6 of a set's setup register (cfg_addr = {set, 1'b0}). Code 00 gives 4 clocks of addr_valid before the strobe, 01 gives 2, 10 gives 3 and 11 gives 5.
- R3: A write to a setup register changes only bits 7:6. Bits 5:0 keep their value and always read back as 0.
- R4: The timing register (cfg_addr = {set, 1'b1}) holds the active count in bits 7:4 and the recovery count in bits 3:0. A nibble of 0 means 16 clocks. The register reads back as the byte written.
- R5: The strobe stays low for at least 2 clocks. An active nibble of 1 gives 2 clocks.
- R6: When chip_rev is greater than 1, recovery lasts the recovery count plus one clock. For chip_rev 0 or 1 it lasts exactly the count.
- R7: Drive 0 uses set 0 and drive 1 uses set 1. Drives 2 and 3 both use set 2. Writes to set 3 (cfg_addr 6 or 7) are ignored, and set 3 reads back as 0.
- R8: A start accepted at a clock edge raises busy and addr_valid in the next cycle. rw_read = 1 selects rd_strobe_n and rw_read = 0 selects wr_strobe_n; only one strobe is ever low. addr_valid stays high through the active phase and is low during recovery.
- R9: done is high for exactly one cycle, right after the last recovery cycle. In that cycle busy is already 0.
- R10: A start that arrives while busy is high is ignored. It changes neither the running transfer nor anything after done.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write enable |
| cfg_addr | input | 3 | Register address: {set[1:0], 0 = setup, 1 = timing} |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the addressed register (combinational) |
| chip_rev | input | 2 | Chip revision; a value above 1 adds a recovery clock |
| start | input | 1 | Transfer request, sampled while idle |
| drive_sel | input | 2 | Target drive 0..3 |
| rw_read | input | 1 | 1 = read strobe, 0 = write strobe |
| addr_valid | output | 1 | Address valid during setup and active |
| rd_strobe_n | output | 1 | Active-low read strobe |
| wr_strobe_n | output | 1 | Active-low write strobe |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle pulse after recovery |

## Verification
After a start is sampled, the first setup cycle comes one clock later. The strobe falls S clocks after that, recovery begins A clocks later, and done appears R clocks after recovery begins. A register write shows up on cfg_rdata in the cycle after its edge. The bench samples every output on the falling edge. It classifies each cycle of a transfer as setup, active or recovery, so each phase length is counted exactly, and it looks again one cycle after done to confirm the pulse has ended and no ignored start has launched a transfer.

// File: rtl/ide_tim_pkg.sv
package ide_tim_pkg;
  localparam int CNT_W = 5;

  typedef enum logic [1:0] {PH_IDLE, PH_SETUP, PH_ACT, PH_REC} phase_e;

  typedef struct packed {
    logic [CNT_W-1:0] setup;
    logic [CNT_W-1:0] active;
    logic [CNT_W-1:0] recov;
  } tim_cnt_t;

  // drives 2 and 3 share the secondary set
  function automatic logic [1:0] drive_to_set(input logic [1:0] drv);
    return drv[1] ? 2'd2 : drv;
  endfunction

  // non-linear address setup encoding
  function automatic logic [CNT_W-1:0] setup_clocks(input logic [1:0] code);
    case (code)
      2'b00:   return CNT_W'(4);
      2'b01:   return CNT_W'(2);
      2'b10:   return CNT_W'(3);
      default: return CNT_W'(5);
    endcase
  endfunction

  // zero nibble stands for sixteen
  function automatic logic [CNT_W-1:0] nib_clocks(input logic [3:0] nib);
    return (nib == 4'd0) ? CNT_W'(16) : CNT_W'(nib);
  endfunction
endpackage

// File: rtl/ide_tim_regs.sv
module ide_tim_regs
  import ide_tim_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int SET_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SET_W:0]   cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic [SET_W-1:0] rd_set,
  output logic [1:0]       rd_code,
  output logic [7:0]       rd_timing
);
  localparam int NUM_SLOTS = 2 ** SET_W;

  logic [1:0] code_q   [NUM_SLOTS];
  logic [7:0] timing_q [NUM_SLOTS];

  logic [SET_W-1:0] wr_set;
  assign wr_set = cfg_addr[SET_W:1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        code_q[i]   <= 2'b00;
        timing_q[i] <= 8'h00;
      end
    end else if (cfg_we) begin
      for (int i = 0; i < NUM_SLOTS; i++) begin
        if (i < NUM_SETS && wr_set == SET_W'(i)) begin
          if (cfg_addr[0]) timing_q[i] <= cfg_wdata;
          else             code_q[i]   <= cfg_wdata[7:6];
        end
      end
    end
  end

  assign rd_code   = code_q[rd_set];
  assign rd_timing = timing_q[rd_set];

  always_comb begin
    if (cfg_addr[0]) cfg_rdata = timing_q[wr_set];
    else             cfg_rdata = {code_q[wr_set], 6'b000000};
  end
endmodule

// File: rtl/ide_tim_decode.sv
module ide_tim_decode
  import ide_tim_pkg::*;
(
  input  logic [1:0] code,
  input  logic [7:0] timing,
  input  logic [1:0] chip_rev,
  output tim_cnt_t   cnt
);
  logic [CNT_W-1:0] act_raw;
  logic [CNT_W-1:0] rec_raw;

  always_comb begin
    act_raw    = nib_clocks(timing[7:4]);
    rec_raw    = nib_clocks(timing[3:0]);
    cnt.setup  = setup_clocks(code);
    cnt.active = (act_raw < CNT_W'(2)) ? CNT_W'(2) : act_raw;
    cnt.recov  = (chip_rev > 2'd1) ? rec_raw + CNT_W'(1) : rec_raw;
  end
endmodule

// File: rtl/ide_tim_seq.sv
module ide_tim_seq
  import ide_tim_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     rw_read,
  input  tim_cnt_t cnt_in,
  output logic     addr_valid,
  output logic     rd_strobe_n,
  output logic     wr_strobe_n,
  output logic     busy,
  output logic     done
);
  phase_e           ph_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] act_q;
  logic [CNT_W-1:0] rec_q;
  logic             rd_q;
  logic             done_q;
  logic             last;

  assign last = (cnt_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      cnt_q  <= '0;
      act_q  <= '0;
      rec_q  <= '0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (ph_q)
        PH_IDLE: if (start) begin
          ph_q  <= PH_SETUP;
          cnt_q <= cnt_in.setup - CNT_W'(1);
          act_q <= cnt_in.active;
          rec_q <= cnt_in.recov;
          rd_q  <= rw_read;
        end
        PH_SETUP: if (last) begin
          ph_q  <= PH_ACT;
          cnt_q <= act_q - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        PH_ACT: if (last) begin
          ph_q  <= PH_REC;
          cnt_q <= rec_q - CNT_W'(1);
        end else cnt_q <= cnt_q - CNT_W'(1);
        default: if (last) begin
          ph_q   <= PH_IDLE;
          done_q <= 1'b1;
        end else cnt_q <= cnt_q - CNT_W'(1);
      endcase
    end
  end

  assign busy        = (ph_q != PH_IDLE);
  assign addr_valid  = (ph_q == PH_SETUP) || (ph_q == PH_ACT);
  assign rd_strobe_n = !((ph_q == PH_ACT) && rd_q);
  assign wr_strobe_n = !((ph_q == PH_ACT) && !rd_q);
  assign done        = done_q;
endmodule

// File: rtl/ide_pio_strobe_gen.sv
module ide_pio_strobe_gen
  import ide_tim_pkg::*;
#(
  parameter int NUM_SETS = 3,
  parameter int SET_W    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [SET_W:0]   cfg_addr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic [1:0]       chip_rev,
  input  logic             start,
  input  logic [1:0]       drive_sel,
  input  logic             rw_read,
  output logic             addr_valid,
  output logic             rd_strobe_n,
  output logic             wr_strobe_n,
  output logic             busy,
  output logic             done
);
  logic [SET_W-1:0] sel_set;
  logic [1:0]       sel_code;
  logic [7:0]       sel_timing;
  tim_cnt_t         sel_cnt;

  assign sel_set = SET_W'(drive_to_set(drive_sel));

  ide_tim_regs #(.NUM_SETS(NUM_SETS), .SET_W(SET_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_addr  (cfg_addr),
    .cfg_wdata (cfg_wdata),
    .cfg_rdata (cfg_rdata),
    .rd_set    (sel_set),
    .rd_code   (sel_code),
    .rd_timing (sel_timing)
  );

  ide_tim_decode u_dec (
    .code     (sel_code),
    .timing   (sel_timing),
    .chip_rev (chip_rev),
    .cnt      (sel_cnt)
  );

  ide_tim_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .rw_read     (rw_read),
    .cnt_in      (sel_cnt),
    .addr_valid  (addr_valid),
    .rd_strobe_n (rd_strobe_n),
    .wr_strobe_n (wr_strobe_n),
    .busy        (busy),
    .done        (done)
  );
endmodule

// File: rtl/ide_pio_strobe_gen_chk.sv
module ide_pio_strobe_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic start,
  input logic addr_valid,
  input logic rd_strobe_n,
  input logic wr_strobe_n,
  input logic busy,
  input logic done
);
  logic strobe_on;
  assign strobe_on = !rd_strobe_n || !wr_strobe_n;

  a_r8_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_strobe_n && !wr_strobe_n));

  a_r8_strobe_addr: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_on |-> addr_valid);

  a_r8_addr_busy: assert property (@(posedge clk) disable iff (!rst_n)
    addr_valid |-> busy);

  a_r5_active_two: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_on) |=> strobe_on);

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy)));

  a_r10_busy_entry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));
endmodule

bind ide_pio_strobe_gen ide_pio_strobe_gen_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .addr_valid  (addr_valid),
  .rd_strobe_n (rd_strobe_n),
  .wr_strobe_n (wr_strobe_n),
  .busy        (busy),
  .done        (done)
);

// File: tb/tb_ide_pio_strobe_gen.sv
`timescale 1ns/1ps
module tb_ide_pio_strobe_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [1:0] chip_rev = 2'd1;
  logic       start = 1'b0;
  logic [1:0] drive_sel = '0;
  logic       rw_read = 1'b1;
  logic       addr_valid, rd_strobe_n, wr_strobe_n, busy, done;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  ide_pio_strobe_gen dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chip_rev(chip_rev),
    .start(start), .drive_sel(drive_sel), .rw_read(rw_read),
    .addr_valid(addr_valid), .rd_strobe_n(rd_strobe_n),
    .wr_strobe_n(wr_strobe_n), .busy(busy), .done(done)
  );

  function automatic int exp_setup(input logic [1:0] code);
    case (code)
      2'b00: return 4;
      2'b01: return 2;
      2'b10: return 3;
      default: return 5;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] a, input logic [7:0] e, input string req);
    @(negedge clk);
    cfg_addr = a;
    #1;
    chk(cfg_rdata == e, req, $sformatf("readback addr %0d", a), cfg_rdata, e);
  endtask

  // one transfer, counting each phase; poke raises start while busy
  task automatic run_xfer(input logic [1:0] drv, input logic rd,
                          input int es, input int ea, input int er,
                          input bit poke, input string req);
    int s = 0, a = 0, r = 0, n = 0;
    bit seen = 0, bad_pol = 0, busy_at_done = 0;
    @(negedge clk);
    start = 1'b1; drive_sel = drv; rw_read = rd;
    @(negedge clk);
    start = 1'b0;
    while (!seen && n < 200) begin
      if (poke && n == 2) begin
        start = 1'b1; drive_sel = ~drv; rw_read = ~rd;
      end else start = 1'b0;
      if (done) begin
        seen = 1; busy_at_done = busy;
      end else if (!rd_strobe_n || !wr_strobe_n) begin
        a++;
        if (rd ? rd_strobe_n : wr_strobe_n) bad_pol = 1;
      end else if (addr_valid) s++;
      else if (busy) r++;
      n++;
      if (!seen) @(negedge clk);
    end
    start = 1'b0;
    chk(seen, req, "done seen (R9)", seen, 1);
    chk(s == es, req, "setup clocks", s, es);
    chk(a == ea, req, "active clocks", a, ea);
    chk(r == er, req, "recovery clocks", r, er);
    chk(!bad_pol, req, "strobe selection R8", bad_pol, 0);
    chk(!busy_at_done, "R9", "busy at done", busy_at_done, 0);
    @(negedge clk);
    chk(!done, "R9", "done width", done, 0);
    chk(!busy, "R10", "no launch after done", busy, 0);
  endtask

  task automatic t_reset();
    chk(!addr_valid && rd_strobe_n && wr_strobe_n && !busy && !done, "R1",
        "idle outputs", {addr_valid, rd_strobe_n, wr_strobe_n, busy, done}, 5'b01100);
    for (int i = 0; i < 6; i++) rd_chk(3'(i), 8'h00, "R1");
    run_xfer(2'd0, 1'b1, 4, 16, 16, 0, "R1");
    run_xfer(2'd3, 1'b0, 4, 16, 16, 0, "R1");
  endtask

  task automatic t_setup_codes();
    for (int c = 0; c < 4; c++) begin
      wr_reg(3'd0, {2'(c), 6'b000000});
      run_xfer(2'd0, c[0], exp_setup(2'(c)), 16, 16, 0, "R2");
    end
  endtask

  task automatic t_setup_mask();
    wr_reg(3'd0, 8'h7F);
    rd_chk(3'd0, 8'h40, "R3");
    wr_reg(3'd0, 8'hBF);
    rd_chk(3'd0, 8'h80, "R3");
    run_xfer(2'd0, 1'b1, 3, 16, 16, 0, "R3");
  endtask

  task automatic t_timing();
    wr_reg(3'd1, 8'h35);
    rd_chk(3'd1, 8'h35, "R4");
    run_xfer(2'd0, 1'b1, 3, 3, 5, 0, "R4");
    wr_reg(3'd1, 8'hF0);
    run_xfer(2'd0, 1'b0, 3, 15, 16, 0, "R4");
    wr_reg(3'd1, 8'h0F);
    run_xfer(2'd0, 1'b1, 3, 16, 15, 0, "R4");
  endtask

  task automatic t_min_active();
    wr_reg(3'd1, 8'h12);
    run_xfer(2'd0, 1'b1, 3, 2, 2, 0, "R5");
    wr_reg(3'd1, 8'h21);
    run_xfer(2'd0, 1'b0, 3, 2, 1, 0, "R5");
  endtask

  task automatic t_rev();
    wr_reg(3'd1, 8'h33);
    chip_rev = 2'd2;
    run_xfer(2'd0, 1'b1, 3, 3, 4, 0, "R6");
    chip_rev = 2'd3;
    run_xfer(2'd0, 1'b0, 3, 3, 4, 0, "R6");
    chip_rev = 2'd0;
    run_xfer(2'd0, 1'b1, 3, 3, 3, 0, "R6");
    chip_rev = 2'd1;
    run_xfer(2'd0, 1'b1, 3, 3, 3, 0, "R6");
    chip_rev = 2'd2;
    wr_reg(3'd1, 8'h00);
    run_xfer(2'd0, 1'b1, 3, 16, 17, 0, "R6");
    chip_rev = 2'd1;
  endtask

  task automatic t_sets();
    wr_reg(3'd1, 8'h33);
    wr_reg(3'd2, 8'hC0);
    wr_reg(3'd3, 8'h44);
    wr_reg(3'd4, 8'h40);
    wr_reg(3'd5, 8'h56);
    run_xfer(2'd0, 1'b1, 3, 3, 3, 0, "R7");
    run_xfer(2'd1, 1'b0, 5, 4, 4, 0, "R7");
    run_xfer(2'd2, 1'b1, 2, 5, 6, 0, "R7");
    run_xfer(2'd3, 1'b0, 2, 5, 6, 0, "R7");
    wr_reg(3'd6, 8'hFF);
    wr_reg(3'd7, 8'h99);
    rd_chk(3'd6, 8'h00, "R7");
    rd_chk(3'd7, 8'h00, "R7");
    rd_chk(3'd0, 8'h80, "R7");
    rd_chk(3'd1, 8'h33, "R7");
    rd_chk(3'd2, 8'hC0, "R7");
    rd_chk(3'd3, 8'h44, "R7");
    rd_chk(3'd4, 8'h40, "R7");
    rd_chk(3'd5, 8'h56, "R7");
    run_xfer(2'd3, 1'b1, 2, 5, 6, 0, "R7");
  endtask

  task automatic t_busy_ignore();
    run_xfer(2'd2, 1'b1, 2, 5, 6, 1, "R10");
    run_xfer(2'd1, 1'b0, 5, 4, 4, 1, "R10");
  endtask

  task automatic t_accept_latency();
    @(negedge clk);
    start = 1'b1; drive_sel = 2'd1; rw_read = 1'b1;
    chk(!busy, "R8", "busy before edge", busy, 0);
    @(negedge clk);
    start = 1'b0;
    chk(busy && addr_valid && rd_strobe_n, "R8", "first setup cycle",
        {busy, addr_valid, rd_strobe_n}, 3'b111);
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setup_codes();
    t_setup_mask();
    t_timing();
    t_min_active();
    t_rev();
    t_sets();
    t_busy_ignore();
    t_accept_latency();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    #1_000_000;
    if (!finished) begin
      finished = 1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule